// File: doc/BRIEF.md
# Synchronous Multi-Rate Capture Pulse Generator

This block drives two related test clocks from one fast input clock: the fast clock itself and a slower clock divided down from it by a programmable ratio. Because both come from the same source, paths between the two domains can be tested as synchronous. During scan shift both outputs carry the same slow pulses. During capture, the pulse timing is set by the slow clock, and the fast clock is gated so that it, too, emits exactly two pulses placed at matching points of the slow periods.

A direction control picks where the fast pulses fall inside each slow period. The last fast cycle serves paths launched in the slow domain and captured in the fast one. The first fast cycle serves paths launched in the fast domain and captured in the slow one. A pass-through control turns the pulse gating off, so that a chain of such stages can have exactly one stage active. Only the first stage divides. A stage further down takes the outputs of the stage before it.

Top module: `mrate_capture_gen`

## Requirements
- R1: While rst_n is low, neither clk_fast_out nor clk_slow_out pulses.
- R2: The slow period is ratio_sel+1 fast cycles for ratio_sel values 1 to 7. A ratio_sel of 0 acts as a period of 2.
- R3: With pass_thru low and scan_en high, both outputs pulse once per slow period on the same fast edge, whatever the value of dir_f2s.
- R4: After scan_en falls with pass_thru low, clk_slow_out gives exactly two pulses, one slow period apart, and clk_fast_out gives exactly two pulses. After that neither output pulses until scan_en rises again.
- R5: The first capture pulse on clk_slow_out comes at the next slow-period boundary, between 2 and ratio+1 fast edges after the fast edge that ends the cycle in which scan_en falls.
- R6: With dir_f2s = 1 (fast-to-slow), each capture pulse on clk_fast_out falls on the same fast edge as a clk_slow_out pulse.
- R7: With dir_f2s = 0 (slow-to-fast), each capture pulse on clk_fast_out comes ratio-1 fast edges after the clk_slow_out pulse of the same slow period, which is the last fast cycle of that period.
- R8: With pass_thru high, clk_fast_out pulses on every fast edge and clk_slow_out pulses once per slow period, whatever scan_en does.
- R9: When pass_thru falls while scan_en is low, neither output pulses until scan_en has risen and fallen again. That next fall then starts a normal capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast_in | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Divide selector: period is ratio_sel+1 (0 acts as 2) |
| scan_en | input | 1 | High for shift, low for capture |
| dir_f2s | input | 1 | 1 = fast-to-slow placement, 0 = slow-to-fast |
| pass_thru | input | 1 | Disables gating; outputs run free |
| clk_fast_out | output | 1 | Gated fast clock |
| clk_slow_out | output | 1 | Gated divided clock |

## Verification
Some rules are checked on every cycle at the clock-enable level. In shift, both enables are equal. In pass-through, the fast enable is always on. In fast-to-slow capture, every fast enable coincides with a slow enable. In slow-to-fast capture, the two never coincide. A capture never grants more than two enables per domain. Other behaviour only shows over the bench's scenarios, because it spans whole slow periods. These are the exact spacing of the two slow pulses for each ratio, the fast-pulse offset of ratio-1 edges, the wait for the next boundary, the silence after capture and after leaving pass-through, and the pulse counts seen at the gated clock ports.

// File: rtl/mrate_capture_gen.sv
`timescale 1ns/1ps
module mrate_capture_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk_fast_in,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             scan_en,
  input  logic             dir_f2s,
  input  logic             pass_thru,
  output logic             clk_fast_out,
  output logic             clk_slow_out
);
  typedef enum logic [1:0] {ST_ARMED, ST_CAP1, ST_CAP2, ST_DONE} st_t;

  st_t             st;
  logic [SEL_W-1:0] cnt, last;
  logic            wrap, first, cap, fast_en, slow_en, fast_en_l, slow_en_l;

  assign last  = (ratio_sel == '0) ? SEL_W'(1) : ratio_sel;
  assign wrap  = (cnt >= last);
  assign first = (cnt == '0);
  assign cap   = (st == ST_CAP1) || (st == ST_CAP2);

  always_ff @(posedge clk_fast_in or negedge rst_n)
    if (!rst_n)   cnt <= '0;
    else if (wrap) cnt <= '0;
    else          cnt <= cnt + 1'b1;

  always_ff @(posedge clk_fast_in or negedge rst_n)
    if (!rst_n)        st <= ST_DONE;
    else if (pass_thru) st <= ST_DONE;
    else if (scan_en)   st <= ST_ARMED;
    else if (wrap)
      case (st)
        ST_ARMED: st <= ST_CAP1;
        ST_CAP1:  st <= ST_CAP2;
        ST_CAP2:  st <= ST_DONE;
        default:  st <= ST_DONE;
      endcase

  always_comb begin
    if (!rst_n) begin
      slow_en = 1'b0;
      fast_en = 1'b0;
    end else if (pass_thru) begin
      slow_en = first;
      fast_en = 1'b1;
    end else if (scan_en) begin
      slow_en = first;
      fast_en = first;
    end else begin
      slow_en = cap & first;
      fast_en = cap & (dir_f2s ? first : wrap);
    end
  end

  always_latch
    if (!clk_fast_in) begin
      fast_en_l = fast_en;
      slow_en_l = slow_en;
    end

  assign clk_fast_out = clk_fast_in & fast_en_l;
  assign clk_slow_out = clk_fast_in & slow_en_l;
endmodule

// File: rtl/mrate_capture_gen_chk.sv
`timescale 1ns/1ps
module mrate_capture_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic scan_en,
  input logic pass_thru,
  input logic dir_f2s,
  input logic fast_en,
  input logic slow_en
);
  logic [1:0] n_slow, n_fast;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      n_slow <= '0;
      n_fast <= '0;
    end else if (scan_en || pass_thru) begin
      n_slow <= '0;
      n_fast <= '0;
    end else begin
      if (slow_en && n_slow != 2'd3) n_slow <= n_slow + 1'b1;
      if (fast_en && n_fast != 2'd3) n_fast <= n_fast + 1'b1;
    end

  p_shift_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !pass_thru) |-> (fast_en == slow_en));
  p_bypass_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass_thru |-> fast_en);
  p_f2s_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_thru && !scan_en && dir_f2s && fast_en) |-> slow_en);
  p_s2f_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_thru && !scan_en && !dir_f2s && fast_en) |-> !slow_en);
  p_two_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    n_slow <= 2'd2);
  p_two_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    n_fast <= 2'd2);
endmodule

bind mrate_capture_gen mrate_capture_gen_chk u_chk (
  .clk(clk_fast_in), .rst_n(rst_n), .scan_en(scan_en), .pass_thru(pass_thru),
  .dir_f2s(dir_f2s), .fast_en(fast_en), .slow_en(slow_en)
);

// File: tb/tb_mrate_capture_gen.sv
`timescale 1ns/1ps
module tb_mrate_capture_gen;
  logic clk = 1'b0, rst_n = 1'b0, scan_en = 1'b1, dir_f2s = 1'b0, pass_thru = 1'b0;
  logic [2:0] ratio_sel = 3'd1;
  logic clk_fast_out, clk_slow_out;
  int errors = 0, checks = 0, cyc = 0;
  int fcnt, scnt, bcnt, s0, s1, f0, f1;

  mrate_capture_gen dut (
    .clk_fast_in(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .scan_en(scan_en),
    .dir_f2s(dir_f2s), .pass_thru(pass_thru),
    .clk_fast_out(clk_fast_out), .clk_slow_out(clk_slow_out)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (clk_fast_out) begin
      fcnt++;
      if (f0 < 0) f0 = cyc; else if (f1 < 0) f1 = cyc;
    end
    if (clk_slow_out) begin
      scnt++;
      if (s0 < 0) s0 = cyc; else if (s1 < 0) s1 = cyc;
    end
    if (clk_fast_out && clk_slow_out) bcnt++;
  end

  task automatic clr();
    fcnt = 0; scnt = 0; bcnt = 0; s0 = -1; s1 = -1; f0 = -1; f1 = -1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed { logic [2:0] sel; logic dir; int per; int gap; } vec_t;
  localparam vec_t VECS [6] = '{
    '{3'd1, 1'b0, 2, 1}, '{3'd3, 1'b1, 4, 0}, '{3'd7, 1'b0, 8, 7},
    '{3'd0, 1'b0, 2, 1}, '{3'd5, 1'b1, 6, 0}, '{3'd4, 1'b0, 5, 4}
  };

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int t0;
    clr();
    pass_thru = 1'b1;
    run(10);
    chk("R1 reset fast", fcnt, 0);
    chk("R1 reset slow", scnt, 0);
    @(negedge clk); rst_n = 1'b1; pass_thru = 1'b0;
    run(4);

    for (int i = 0; i < 6; i++) begin
      ratio_sel = VECS[i].sel; dir_f2s = VECS[i].dir; scan_en = 1'b1;
      run(10);
      clr();
      run(4 * VECS[i].per);
      chk("R3 shift slow", scnt, 4);
      chk("R3 shift fast", fcnt, 4);
      chk("R3 shift coincident", bcnt, 4);
      clr();
      t0 = cyc;
      scan_en = 1'b0;
      run(4 * VECS[i].per + 10);
      chk("R4 capture slow count", scnt, 2);
      chk("R4 capture fast count", fcnt, 2);
      chk("R2 slow spacing", s1 - s0, VECS[i].per);
      chk("R5 start at boundary", (s0 - t0 >= 2 && s0 - t0 <= VECS[i].per + 1) ? 1 : 0, 1);
      if (VECS[i].dir) begin
        chk("R6 first fast aligned", f0 - s0, 0);
        chk("R6 second fast aligned", f1 - s1, 0);
      end else begin
        chk("R7 first fast offset", f0 - s0, VECS[i].gap);
        chk("R7 second fast offset", f1 - s1, VECS[i].gap);
      end
    end

    ratio_sel = 3'd2; pass_thru = 1'b1; scan_en = 1'b0;
    run(6); clr(); run(24);
    chk("R8 bypass fast", fcnt, 24);
    chk("R8 bypass slow", scnt, 8);
    scan_en = 1'b1;
    run(6); clr(); run(24);
    chk("R8 bypass fast scan", fcnt, 24);
    chk("R8 bypass slow scan", scnt, 8);

    scan_en = 1'b0; run(3); pass_thru = 1'b0;
    clr(); run(30);
    chk("R9 silent fast", fcnt, 0);
    chk("R9 silent slow", scnt, 0);
    scan_en = 1'b1; run(6); clr(); scan_en = 1'b0; run(30);
    chk("R9 recapture slow", scnt, 2);
    chk("R9 recapture fast", fcnt, 2);

    scan_en = 1'b1; pass_thru = 1'b1; run(3);
    rst_n = 1'b0; clr(); run(12);
    chk("R1 midrun reset fast", fcnt, 0);
    chk("R1 midrun reset slow", scnt, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule